// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge Interrupts

This block is an eight-line general-purpose I/O port behind a byte-wide register interface. The lower four lines are permanently outputs and the upper four are permanently inputs. The host reaches it through a three-bit offset, a single-cycle write strobe and a combinational read-data bus. Each input line has a two-bit edge-select field that enables rising-edge detection, falling-edge detection, both, or neither. A detected edge on an enabled input sets a sticky pending bit. Any pending bit raises the single interrupt output.

Each input passes through a two-stage synchroniser. It then feeds a two-state level tracker. The states are `LVL_LOW` and `LVL_HIGH`, and both reset to `LVL_LOW`:

- While in `LVL_LOW`, seeing a synchronised 1 takes the transition *rise* to `LVL_HIGH` and emits a one-cycle rising event.
- While in `LVL_HIGH`, seeing a 0 takes the transition *fall* to `LVL_LOW` and emits a falling event.
- Seeing the same level takes the transition *hold* and emits nothing.

Pending bits are cleared by writing ones to them. This matches the usual host sequence of reading the pending byte and then writing the same value back.

Register offsets:

- Offset 0: direction, fixed.
- Offset 1: line data.
- Offset 2: reserved.
- Offset 3: edge configuration.
- Offset 4: pending status.

Top module: `fdg_gpio_port`

## Requirements
- R1: After reset the outputs `gpo` are 0, the configuration register reads 0, the pending register reads 0 and `irq` is 0.
- R2: Offset 0 always reads 0x0F, meaning the low nibble is outputs and the high nibble is inputs. Writes to offset 0 change nothing.
- R3: A write to offset 1 drives `gpo` from write bits [3:0] on the next clock. Write bits [7:4] have no effect. `gpo` changes only on such writes.
- R4: Reading offset 1 returns {synchronised inputs, current outputs}. An input change shows in read bits [7:4] two clock edges after it is applied, and not after one.
- R5: Offset 3 stores a byte that reads back unchanged. In it, input n (pin n+4) owns bits [2n+1:2n]: bit 2n enables falling edges and bit 2n+1 enables rising edges.
- R6: With a field value of 2, a rising edge on input n sets pending bit n at the third clock edge after the pin change. A falling edge does not set it.
- R7: With a field value of 1, only a falling edge on input n sets pending bit n.
- R8: With a field value of 3, both rising and falling edges on input n set pending bit n.
- R9: With a field value of 0, input n is masked. Its edges set nothing, and enabling the field later does not recover an edge that arrived while masked.
- R10: Pending bits (offset 4, bit n for pin n+4) stay set until the host writes a 1 to that bit. Writing a 0 leaves the bit unchanged.
- R11: `irq` is 1 exactly when at least one pending bit is set.
- R12: If a new enabled edge on input n coincides with a write clearing pending bit n, the bit stays set.
- R13: Offset 2 reads 0, and writes to it change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| gpo | output | 4 | Output lines 0-3 |
| gpi | input | 4 | Asynchronous input lines 4-7 |
| irq | output | 1 | Interrupt request, high while any event is pending |

## Verification
A level tracker stuck in the wrong state would first show up as a missing or spurious pending bit. That bit becomes visible on `irq` and on the offset-4 read three clock edges after the offending pin change. A wrong output latch shows on `gpo` one edge after the write that should have moved it. A pending bit that is lost or cleared without cause shows on `irq` in the cycle after it happens, unless another bit is still pending. For that reason the bench reads the offset-4 byte itself, not just `irq`. The same-cycle set-and-clear collision is driven at the exact edge, so that a design that lets the clear win reports zero instead of the expected bit.

// File: rtl/fdg_pkg.sv
package fdg_pkg;
    localparam int unsigned REG_ADDR_W = 3;
    localparam int unsigned FIELD_W    = 2;

    localparam logic [REG_ADDR_W-1:0] OFS_DIR  = 3'd0;
    localparam logic [REG_ADDR_W-1:0] OFS_DATA = 3'd1;
    localparam logic [REG_ADDR_W-1:0] OFS_RSVD = 3'd2;
    localparam logic [REG_ADDR_W-1:0] OFS_CFG  = 3'd3;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT = 3'd4;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/fdg_sync.sv
module fdg_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fdg_edge_fsm.sv
module fdg_edge_fsm
    import fdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    lvl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // next state: rise, fall or hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl) state_d = LVL_LOW;
        endcase
    end

    // outputs: one-cycle event on each transition
    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = lvl;
            LVL_HIGH: fall = !lvl;
        endcase
    end
endmodule

// File: rtl/fdg_irq_status.sv
module fdg_irq_status
    import fdg_pkg::*;
#(
    parameter int unsigned NUM_IN = 4,
    localparam int unsigned CFG_W = NUM_IN * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [NUM_IN-1:0] rise,
    input  logic [NUM_IN-1:0] fall,
    input  logic              clr_en,
    input  logic [NUM_IN-1:0] clr_mask,
    output logic [NUM_IN-1:0] status,
    output logic              irq
);
    logic [NUM_IN-1:0] hit;
    logic [NUM_IN-1:0] status_q;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
        // bit 2i = falling enable, bit 2i+1 = rising enable
        assign hit[i] = (fall[i] & cfg[FIELD_W*i]) |
                        (rise[i] & cfg[FIELD_W*i+1]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                status_q[i] <= 1'b0;
            else if (hit[i])
                status_q[i] <= 1'b1;          // set beats clear
            else if (clr_en && clr_mask[i])
                status_q[i] <= 1'b0;
        end
    end

    assign status = status_q;
    assign irq    = |status_q;
endmodule

// File: rtl/fdg_gpio_port.sv
module fdg_gpio_port
    import fdg_pkg::*;
#(
    parameter int unsigned NUM_OUT   = 4,
    parameter int unsigned NUM_IN    = 4,
    parameter int unsigned SYNC_STGS = 2,
    localparam int unsigned BYTE_W   = NUM_OUT + NUM_IN,
    localparam int unsigned CFG_W    = NUM_IN * FIELD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    output logic [NUM_OUT-1:0]    gpo,
    input  logic [NUM_IN-1:0]     gpi,
    output logic                  irq
);
    localparam logic [BYTE_W-1:0] DIR_VALUE = BYTE_W'((1 << NUM_OUT) - 1);

    logic [NUM_OUT-1:0] out_q;
    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_IN-1:0]  in_sync;
    logic [NUM_IN-1:0]  rise_evt, fall_evt;
    logic [NUM_IN-1:0]  status_q;
    logic               wr_data, wr_cfg, wr_stat;

    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign wr_cfg  = bus_wr && (bus_addr == OFS_CFG);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            cfg_q <= '0;
        end else begin
            if (wr_data) out_q <= bus_wdata[NUM_OUT-1:0];
            if (wr_cfg)  cfg_q <= bus_wdata[CFG_W-1:0];
        end
    end

    fdg_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gpi),
        .dout (in_sync)
    );

    for (genvar n = 0; n < NUM_IN; n++) begin : g_edge
        fdg_edge_fsm u_fsm (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (in_sync[n]),
            .rise (rise_evt[n]),
            .fall (fall_evt[n])
        );
    end

    fdg_irq_status #(.NUM_IN(NUM_IN)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg_q),
        .rise    (rise_evt),
        .fall    (fall_evt),
        .clr_en  (wr_stat),
        .clr_mask(bus_wdata[NUM_IN-1:0]),
        .status  (status_q),
        .irq     (irq)
    );

    always_comb begin
        case (bus_addr)
            OFS_DIR:  bus_rdata = DIR_VALUE;
            OFS_DATA: bus_rdata = {in_sync, out_q};
            OFS_CFG:  bus_rdata = BYTE_W'(cfg_q);
            OFS_STAT: bus_rdata = BYTE_W'(status_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign gpo = out_q;
endmodule

// File: rtl/fdg_gpio_port_chk.sv
module fdg_gpio_port_chk
    import fdg_pkg::*;
#(
    parameter int unsigned NUM_OUT = 4,
    parameter int unsigned NUM_IN  = 4,
    localparam int unsigned BYTE_W = NUM_OUT + NUM_IN,
    localparam int unsigned CFG_W  = NUM_IN * FIELD_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic                  bus_wr,
    input logic [BYTE_W-1:0]     bus_wdata,
    input logic [BYTE_W-1:0]     bus_rdata,
    input logic [NUM_OUT-1:0]    gpo,
    input logic                  irq,
    input logic [CFG_W-1:0]      cfg_q,
    input logic [NUM_IN-1:0]     status_q
);
    localparam logic [BYTE_W-1:0] DIR_EXP = BYTE_W'((1 << NUM_OUT) - 1);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (gpo == '0 && !irq && cfg_q == '0));

    p_dir_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_DIR) |-> (bus_rdata == DIR_EXP));

    p_gpo_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA) |=> (gpo == $past(bus_wdata[NUM_OUT-1:0])));

    p_gpo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_DATA) |=> $stable(gpo));

    p_cfg_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CFG) |=> (cfg_q == $past(bus_wdata[CFG_W-1:0])));

    p_masked_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0) |=> ((status_q & ~$past(status_q)) == '0));

    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STAT && cfg_q == '0)
        |=> ((status_q & $past(bus_wdata[NUM_IN-1:0])) == '0));

    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && bus_addr == OFS_STAT)) |=> irq);

    p_rsvd_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_RSVD) |-> (bus_rdata == '0));
endmodule

bind fdg_gpio_port fdg_gpio_port_chk #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .gpo      (gpo),
    .irq      (irq),
    .cfg_q    (cfg_q),
    .status_q (status_q)
);

// File: tb/fdg_gpio_port_bench.sv
module fdg_gpio_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] gpo;
    logic [3:0] gpi = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fdg_gpio_port u_fdg_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpo(gpo), .gpi(gpi), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // apply pins, then wait until an event would be recorded
    task automatic drive_pins(input logic [3:0] v);
        @(negedge clk);
        gpi = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 gpo", {4'h0, gpo}, 8'h00);
        bus_read(3'd3, d); check("R1 cfg", d, 8'h00);
        bus_read(3'd4, d); check("R1 status", d, 8'h00);
        check("R1 irq", {7'h0, irq}, 8'h00);
    endtask

    task automatic t_dir();
        logic [7:0] d;
        bus_read(3'd0, d); check("R2 dir", d, 8'h0F);
        bus_write(3'd0, 8'hF0);
        bus_read(3'd0, d); check("R2 dir after write", d, 8'h0F);
        check("R2 gpo untouched", {4'h0, gpo}, 8'h00);
    endtask

    task automatic t_data_out();
        logic [7:0] d;
        bus_write(3'd1, 8'hA5);
        check("R3 gpo low nibble", {4'h0, gpo}, 8'h05);
        bus_read(3'd1, d); check("R3 data readback", d, 8'h05);
        bus_write(3'd1, 8'hF0);
        check("R3 high nibble ignored", {4'h0, gpo}, 8'h00);
        bus_read(3'd1, d); check("R3 inputs not written", d, 8'h00);
        bus_write(3'd1, 8'h0C);
        check("R3 gpo C", {4'h0, gpo}, 8'h0C);
    endtask

    task automatic t_data_in();
        logic [7:0] d;
        @(negedge clk);
        gpi = 4'h9;
        @(posedge clk); @(negedge clk);
        bus_read(3'd1, d); check("R4 one edge old", d, 8'h0C);
        @(posedge clk); @(negedge clk);
        bus_read(3'd1, d); check("R4 two edges new", d, 8'h9C);
        drive_pins(4'h0);
        bus_read(3'd4, d); check("R4 no status when masked", d, 8'h00);
    endtask

    task automatic t_cfg();
        logic [7:0] d;
        bus_write(3'd3, 8'hE4);
        bus_read(3'd3, d); check("R5 cfg readback", d, 8'hE4);
        bus_write(3'd3, 8'h00);
    endtask

    task automatic t_rise();
        logic [7:0] d;
        bus_write(3'd3, 8'h02);
        @(negedge clk);
        gpi = 4'h1;
        repeat (2) @(posedge clk); @(negedge clk);
        bus_read(3'd4, d); check("R6 not before third edge", d, 8'h00);
        @(posedge clk); @(negedge clk);
        bus_read(3'd4, d); check("R6 rise sets", d, 8'h01);
        check("R11 irq on", {7'h0, irq}, 8'h01);
        bus_write(3'd4, 8'h01);
        drive_pins(4'h0);
        bus_read(3'd4, d); check("R6 fall ignored", d, 8'h00);
        check("R11 irq off", {7'h0, irq}, 8'h00);
    endtask

    task automatic t_fall();
        logic [7:0] d;
        bus_write(3'd3, 8'h04);
        drive_pins(4'h2);
        bus_read(3'd4, d); check("R7 rise ignored", d, 8'h00);
        drive_pins(4'h0);
        bus_read(3'd4, d); check("R7 fall sets", d, 8'h02);
        bus_write(3'd4, 8'h02);
    endtask

    task automatic t_both();
        logic [7:0] d;
        bus_write(3'd3, 8'h30);
        drive_pins(4'h4);
        bus_read(3'd4, d); check("R8 rise sets", d, 8'h04);
        bus_write(3'd4, 8'h04);
        drive_pins(4'h0);
        bus_read(3'd4, d); check("R8 fall sets", d, 8'h04);
        bus_write(3'd4, 8'h04);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        bus_write(3'd3, 8'h00);
        drive_pins(4'h8);
        bus_read(3'd4, d); check("R9 masked rise", d, 8'h00);
        bus_write(3'd3, 8'hC0);
        repeat (2) @(negedge clk);
        bus_read(3'd4, d); check("R9 not recovered", d, 8'h00);
        bus_write(3'd3, 8'h00);
        drive_pins(4'h0);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        bus_write(3'd3, 8'hFF);
        drive_pins(4'h9);
        bus_read(3'd4, d); check("R10 two pending", d, 8'h09);
        bus_write(3'd4, 8'h00);
        bus_read(3'd4, d); check("R10 zero write keeps", d, 8'h09);
        bus_write(3'd4, 8'h01);
        bus_read(3'd4, d); check("R10 partial clear", d, 8'h08);
        check("R11 irq still on", {7'h0, irq}, 8'h01);
        bus_write(3'd4, 8'h08);
        check("R11 irq cleared", {7'h0, irq}, 8'h00);
        drive_pins(4'h0);
        bus_read(3'd4, d); check("R10 falls set again", d, 8'h09);
        bus_write(3'd4, 8'h0F);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        drive_pins(4'h2);
        bus_read(3'd4, d); check("R12 setup", d, 8'h02);
        @(negedge clk);
        gpi = 4'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(3'd4, d); check("R12 set wins", d, 8'h02);
        bus_write(3'd4, 8'h02);
        bus_read(3'd4, d); check("R12 later clear", d, 8'h00);
    endtask

    task automatic t_rsvd();
        logic [7:0] d;
        bus_write(3'd2, 8'hFF);
        bus_read(3'd2, d); check("R13 reads zero", d, 8'h00);
        check("R13 gpo kept", {4'h0, gpo}, 8'h0C);
        bus_read(3'd3, d); check("R13 cfg kept", d, 8'hFF);
        bus_read(3'd4, d); check("R13 status kept", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_data_out();
        t_data_in();
        t_cfg();
        t_rise();
        t_fall();
        t_both();
        t_mask();
        t_w1c();
        t_collide();
        t_rsvd();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule